// File: doc/BRIEF.md
# Display Panel Power-Down Sequencer

This block takes a display panel from a running state to a verified unpowered state. It works in a set dependency order, and it will not allow a new power-up until that state is reached. On a shutdown request it asks the panel command engine for a display-off command and then a sleep-entry command. After each command it waits a set number of frame periods. It then parks the host interface pins and switches the panel supply rails off one at a time. The order of the rails and the delay after each rail are parameters. This lets a design turn a bias rail off, and let it fall, before the emission rails go.

When the last rail is off, the block watches one below-threshold comparator per rail. It also counts a minimum off time. Permission to restart is given only when both conditions hold. If the rails do not discharge within a timeout, the block raises an error and stays blocked until reset.

A rail fault reported while rails may be up turns off that rail and every rail that depends on it at once. The block records the failing domain and continues with the ordered power-down without sending any panel commands. Consecutive fault-driven shutdowns are counted, and a set number of them locks out restart. A shutdown that arrives part way through power-up enters the sequence at the step that matches how far power-up had got.

Top module: `sd_shutdown_seq`

## Requirements
- R1: While reset is held, every bit of `rail_off` is 1, `if_park` is 1, and `cmd_req`, `restart_ok`, `fault_flag`, `dis_err` and `retry_lock` are 0.
- R2: A shutdown request with `up_stage` = 3 (display showing) raises `cmd_req` with `cmd_sel` = 0 (display off). The request is held with a stable `cmd_sel` until `cmd_ack`. After the acknowledge, `cmd_req` rises again with `cmd_sel` = 1 (sleep entry) on the FRAMES_DOFF-th `frame_tick` pulse, and not before it.
- R3: After the sleep-entry acknowledge and FRAMES_SLP frame ticks, `if_park` goes to 1 and the rails turn off one per step in the order of RAIL_ORDER. Step k uses the 4-bit field k. The rail of step k+1 turns off exactly STEP_DLY field k + 2 clock cycles after the rail of step k, where STEP_DLY field k is 16 bits at bit k*16.
- R4: A shutdown request with `up_stage` = 2 (controller ready) starts at the sleep-entry command. With `up_stage` = 1 or 0, no command is requested and the rail steps start at once.
- R5: `restart_ok` is 1 only in the off state, with every `rail_low` bit at 1, and after at least MIN_OFF cycles of discharge watching. The discharge watch starts at reset or after the delay of the last rail step. If a comparator stays high, restart is withheld past MIN_OFF.
- R6: If the rails are not all below threshold within DIS_TMO cycles of discharge watching, `dis_err` goes to 1. It stays at 1, and `restart_ok` stays at 0, until reset, even if the rails later discharge.
- R7: A `rail_fault` bit seen while rails may be up turns off, from the next cycle, that rail and every rail in its DEP_MASK row. The row for rail i is 8 bits at bit i*8. `fault_flag` goes to 1 and `fault_dom` takes the lowest faulting index. No command is requested, and the rail steps run from step 0.
- R8: `rail_fault` has no effect in the discharge, off and error states: `fault_flag` stays 0 and `rail_off` is unchanged.
- R9: After MAX_RETRY consecutive fault-driven shutdowns, `retry_lock` is 1 and `restart_ok` stays 0 until reset. A shutdown from a plain request clears the count.
- R10: In the off state, a nonzero `up_stage` while `restart_ok` is 1 enters the running state. In the running state `rail_off` is all 0 and `if_park` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_stage | input | 2 | Power-up progress: 0 none, 1 rails up, 2 controller ready, 3 display showing |
| shut_req | input | 1 | Shutdown request pulse |
| frame_tick | input | 1 | One pulse per frame period |
| cmd_ack | input | 1 | Command engine has accepted the requested command |
| rail_fault | input | N_RAIL | Per-rail fault report |
| rail_low | input | N_RAIL | Per-rail below-off-threshold comparator |
| cmd_req | output | 1 | Panel command request, held until acknowledge |
| cmd_sel | output | 1 | Requested command: 0 display off, 1 sleep entry |
| if_park | output | 1 | Hold interface and control pins in their safe state |
| rail_off | output | N_RAIL | Per-rail force-off |
| restart_ok | output | 1 | A new power-up may begin |
| fault_flag | output | 1 | A rail fault was recorded in this cycle of operation |
| fault_dom | output | IDXW | Index of the recorded faulting rail |
| dis_err | output | 1 | Discharge timeout reached |
| retry_lock | output | 1 | Fault retry limit reached |

## Verification
The bench builds the block with four rails and short settings: step delays of 5, 2, 3 and 1, two and three frames of command wait, MIN_OFF of 40, DIS_TMO of 200 and MAX_RETRY of 2. These values are small enough that the bench can count the exact rail spacing and the boundary between too-early and permitted restart. They also let it reach a discharge timeout and a retry lockout within a short run. The dependency rows are chosen so that one fault kills a subset of rails while another kills all of them, and one stimulus makes two rails fault in the same cycle.

// File: rtl/sd_pkg.sv
package sd_pkg;

   typedef enum logic [3:0] {
      S_RUN,
      S_DOFF_CMD,
      S_DOFF_WAIT,
      S_SLP_CMD,
      S_SLP_WAIT,
      S_RAIL_OFF,
      S_RAIL_WAIT,
      S_DISCH,
      S_OFF,
      S_ERR
   } sd_state_e;

   localparam logic [1:0] STG_NONE  = 2'd0;
   localparam logic [1:0] STG_RAILS = 2'd1;
   localparam logic [1:0] STG_READY = 2'd2;
   localparam logic [1:0] STG_SHOW  = 2'd3;

   localparam int MAX_RAILS = 8;
   localparam int ORD_FW    = 4;
   localparam int DLY_FW    = 16;
   localparam int DEP_FW    = 8;

   function automatic logic order_is_perm(input logic [31:0] ord, input int n);
      logic [7:0] seen;
      seen = '0;
      for (int i = 0; i < MAX_RAILS; i++) begin
         if (i < n) begin
            if (int'(ord[i*ORD_FW +: ORD_FW]) >= n) return 1'b0;
            seen[ord[i*ORD_FW +: 3]] = 1'b1;
         end
      end
      return int'(seen) == ((1 << n) - 1);
   endfunction

endpackage

// File: rtl/sd_count_timer.sv
module sd_count_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/sd_rail_mask.sv
module sd_rail_mask #(
   parameter int          N_RAIL   = 4,
   parameter int          IDXW     = 2,
   parameter logic [63:0] DEP_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step_kill,
   input  logic [IDXW-1:0]   step_rail,
   input  logic              fault_en,
   input  logic [N_RAIL-1:0] fault_vec,
   output logic [N_RAIL-1:0] rail_off,
   output logic              fault_flag,
   output logic [IDXW-1:0]   fault_dom,
   output logic              fault_new
);

   logic [N_RAIL-1:0] seq_mask;
   logic [N_RAIL-1:0] kill_mask;
   logic [N_RAIL-1:0] kill_row [N_RAIL];
   logic [N_RAIL-1:0] kill_hit;
   logic [IDXW-1:0]   low_idx;

   // each faulting rail expands to itself plus its dependents
   for (genvar i = 0; i < N_RAIL; i++) begin : g_dep
      localparam logic [N_RAIL-1:0] ROW = DEP_MASK[i*8 +: N_RAIL] | (N_RAIL'(1) << i);
      assign kill_row[i] = fault_vec[i] ? ROW : '0;
   end

   always_comb begin
      kill_hit = '0;
      for (int i = 0; i < N_RAIL; i++) kill_hit = kill_hit | kill_row[i];
   end

   always_comb begin
      low_idx = '0;
      for (int i = N_RAIL - 1; i >= 0; i--) begin
         if (fault_vec[i]) low_idx = IDXW'(i);
      end
   end

   assign fault_new = fault_en && (|fault_vec) && !fault_flag;
   assign rail_off  = seq_mask | kill_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_mask   <= '1;
         kill_mask  <= '0;
         fault_flag <= 1'b0;
         fault_dom  <= '0;
      end else if (clr) begin
         seq_mask   <= '0;
         kill_mask  <= '0;
         fault_flag <= 1'b0;
         fault_dom  <= '0;
      end else begin
         if (step_kill) seq_mask[step_rail] <= 1'b1;
         if (fault_en) kill_mask <= kill_mask | kill_hit;
         if (fault_new) begin
            fault_flag <= 1'b1;
            fault_dom  <= low_idx;
         end
      end
   end

endmodule

// File: rtl/sd_discharge_mon.sv
module sd_discharge_mon #(
   parameter int N_RAIL  = 4,
   parameter int MIN_OFF = 1000,
   parameter int DIS_TMO = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [N_RAIL-1:0] rail_low,
   output logic              dis_ok,
   output logic              dis_tmo
);

   localparam int LIMIT = (MIN_OFF > DIS_TMO) ? MIN_OFF : DIS_TMO;
   localparam int CW    = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] CMAX = CW'(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (cnt != CMAX) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign dis_ok = en && (&rail_low) && (cnt >= CW'(MIN_OFF));

   if (DIS_TMO > 0) begin : g_tmo
      assign dis_tmo = en && !dis_ok && (cnt >= CW'(DIS_TMO));
   end else begin : g_no_tmo
      assign dis_tmo = 1'b0;
   end

endmodule

// File: rtl/sd_shutdown_seq.sv
module sd_shutdown_seq
   import sd_pkg::*;
#(
   parameter int           N_RAIL      = 4,
   parameter logic [31:0]  RAIL_ORDER  = 32'h0000_3102,
   parameter logic [127:0] STEP_DLY    = 128'h0003_0003_0003_0440,
   parameter logic [63:0]  DEP_MASK    = 64'h0000_0000_0F03_0002,
   parameter int           FRAMES_DOFF = 2,
   parameter int           FRAMES_SLP  = 2,
   parameter int           MIN_OFF     = 1000,
   parameter int           DIS_TMO     = 5000,
   parameter int           MAX_RETRY   = 3,
   localparam int          IDXW        = (N_RAIL > 1) ? $clog2(N_RAIL) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        up_stage,
   input  logic              shut_req,
   input  logic              frame_tick,
   input  logic              cmd_ack,
   input  logic [N_RAIL-1:0] rail_fault,
   input  logic [N_RAIL-1:0] rail_low,
   output logic              cmd_req,
   output logic              cmd_sel,
   output logic              if_park,
   output logic [N_RAIL-1:0] rail_off,
   output logic              restart_ok,
   output logic              fault_flag,
   output logic [IDXW-1:0]   fault_dom,
   output logic              dis_err,
   output logic              retry_lock
);

   localparam int TW = DLY_FW;
   localparam int RW = $clog2(MAX_RETRY + 1);
   localparam logic [IDXW-1:0] LAST_STEP = IDXW'(N_RAIL - 1);

   // elaboration checks on the configuration
   if (N_RAIL < 1 || N_RAIL > MAX_RAILS) begin : g_bad_n
      $error("sd_shutdown_seq: N_RAIL out of range");
   end
   if (!order_is_perm(RAIL_ORDER, N_RAIL)) begin : g_bad_order
      $error("sd_shutdown_seq: RAIL_ORDER is not a permutation of the rails");
   end
   if (FRAMES_DOFF < 1 || FRAMES_SLP < 1) begin : g_bad_frames
      $error("sd_shutdown_seq: frame waits must be at least one");
   end
   if (MAX_RETRY < 1 || MIN_OFF < 1) begin : g_bad_lim
      $error("sd_shutdown_seq: MAX_RETRY and MIN_OFF must be positive");
   end

   sd_state_e       st, st_n;
   logic [IDXW-1:0] step, step_n;
   logic            tmr_load, tmr_dec;
   logic [TW-1:0]   tmr_val, tmr_cnt;
   logic            step_kill, mask_clr;
   logic            fault_en, fault_seen, fault_new;
   logic            dis_en, dis_ok, dis_tmo;
   logic [IDXW-1:0] step_rail;
   logic [RW-1:0]   retry_cnt;

   assign step_rail = IDXW'(RAIL_ORDER[int'(step)*ORD_FW +: ORD_FW]);

   sd_count_timer #(.W(TW)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .cnt      (tmr_cnt)
   );

   sd_rail_mask #(
      .N_RAIL   (N_RAIL),
      .IDXW     (IDXW),
      .DEP_MASK (DEP_MASK)
   ) u_mask (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (mask_clr),
      .step_kill  (step_kill),
      .step_rail  (step_rail),
      .fault_en   (fault_en),
      .fault_vec  (rail_fault),
      .rail_off   (rail_off),
      .fault_flag (fault_flag),
      .fault_dom  (fault_dom),
      .fault_new  (fault_new)
   );

   sd_discharge_mon #(
      .N_RAIL  (N_RAIL),
      .MIN_OFF (MIN_OFF),
      .DIS_TMO (DIS_TMO)
   ) u_dis (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (dis_en),
      .rail_low (rail_low),
      .dis_ok   (dis_ok),
      .dis_tmo  (dis_tmo)
   );

   assign fault_en   = !(st == S_DISCH || st == S_OFF || st == S_ERR);
   assign fault_seen = fault_en && (|rail_fault);
   assign dis_en     = (st == S_DISCH);

   always_comb begin
      st_n      = st;
      step_n    = step;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      tmr_dec   = 1'b0;
      step_kill = 1'b0;
      mask_clr  = 1'b0;
      unique case (st)
         S_RUN: begin
            if (fault_seen) begin
               st_n   = S_RAIL_OFF;
               step_n = '0;
            end else if (shut_req) begin
               step_n = '0;
               unique case (up_stage)
                  STG_SHOW:  st_n = S_DOFF_CMD;
                  STG_READY: st_n = S_SLP_CMD;
                  default:   st_n = S_RAIL_OFF;
               endcase
            end
         end
         S_DOFF_CMD, S_SLP_CMD: begin
            if (fault_seen) begin
               st_n   = S_RAIL_OFF;
               step_n = '0;
            end else if (cmd_ack) begin
               st_n     = (st == S_DOFF_CMD) ? S_DOFF_WAIT : S_SLP_WAIT;
               tmr_load = 1'b1;
               tmr_val  = (st == S_DOFF_CMD) ? TW'(FRAMES_DOFF) : TW'(FRAMES_SLP);
            end
         end
         S_DOFF_WAIT, S_SLP_WAIT: begin
            if (fault_seen) begin
               st_n   = S_RAIL_OFF;
               step_n = '0;
            end else if (frame_tick) begin
               if (tmr_cnt <= TW'(1)) begin
                  st_n   = (st == S_DOFF_WAIT) ? S_SLP_CMD : S_RAIL_OFF;
                  step_n = '0;
               end else begin
                  tmr_dec = 1'b1;
               end
            end
         end
         S_RAIL_OFF: begin
            step_kill = 1'b1;
            tmr_load  = 1'b1;
            tmr_val   = STEP_DLY[int'(step)*DLY_FW +: DLY_FW];
            st_n      = S_RAIL_WAIT;
         end
         S_RAIL_WAIT: begin
            if (tmr_cnt == '0) begin
               if (step == LAST_STEP) begin
                  st_n = S_DISCH;
               end else begin
                  step_n = step + 1'b1;
                  st_n   = S_RAIL_OFF;
               end
            end else begin
               tmr_dec = 1'b1;
            end
         end
         S_DISCH: begin
            if (dis_ok)       st_n = S_OFF;
            else if (dis_tmo) st_n = S_ERR;
         end
         S_OFF: begin
            if ((up_stage != STG_NONE) && restart_ok) begin
               st_n     = S_RUN;
               mask_clr = 1'b1;
            end
         end
         S_ERR: st_n = S_ERR;
         default: st_n = S_DISCH;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_DISCH;
         step <= '0;
      end else begin
         st   <= st_n;
         step <= step_n;
      end
   end

   // consecutive fault-driven shutdowns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         retry_cnt <= '0;
      end else if (fault_new) begin
         if (retry_cnt != RW'(MAX_RETRY)) retry_cnt <= retry_cnt + 1'b1;
      end else if (st == S_RUN && shut_req) begin
         retry_cnt <= '0;
      end
   end

   assign retry_lock = (retry_cnt >= RW'(MAX_RETRY));
   assign cmd_req    = (st == S_DOFF_CMD) || (st == S_SLP_CMD);
   assign cmd_sel    = (st == S_SLP_CMD);
   assign if_park    = !(st == S_RUN || st == S_DOFF_CMD || st == S_DOFF_WAIT ||
                         st == S_SLP_CMD || st == S_SLP_WAIT);
   assign restart_ok = (st == S_OFF) && (&rail_low) && !retry_lock;
   assign dis_err    = (st == S_ERR);

endmodule

// File: rtl/sd_shutdown_chk.sv
module sd_shutdown_chk #(
   parameter int N_RAIL  = 4,
   parameter int MIN_OFF = 1000,
   parameter int IDXW    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_req,
   input logic              cmd_ack,
   input logic              cmd_sel,
   input logic              if_park,
   input logic [N_RAIL-1:0] rail_off,
   input logic [N_RAIL-1:0] rail_low,
   input logic              restart_ok,
   input logic              fault_flag,
   input logic [IDXW-1:0]   fault_dom,
   input logic              dis_err,
   input logic              retry_lock
);

   logic [31:0] off_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       off_run <= '0;
      else if (!(&rail_off))            off_run <= '0;
      else if (off_run != 32'hFFFF_FFFF) off_run <= off_run + 1'b1;
   end

   p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_sel)));

   p_park_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|rail_off) |-> if_park);

   p_restart_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart_ok |-> ((&rail_low) && (&rail_off)));

   p_min_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      restart_ok |-> (off_run >= 32'(MIN_OFF)));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dis_err |=> (dis_err && !restart_ok));

   p_fault_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> rail_off[fault_dom]);

   p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retry_lock |-> !restart_ok);

endmodule

bind sd_shutdown_seq sd_shutdown_chk #(
   .N_RAIL  (N_RAIL),
   .MIN_OFF (MIN_OFF),
   .IDXW    (IDXW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_req    (cmd_req),
   .cmd_ack    (cmd_ack),
   .cmd_sel    (cmd_sel),
   .if_park    (if_park),
   .rail_off   (rail_off),
   .rail_low   (rail_low),
   .restart_ok (restart_ok),
   .fault_flag (fault_flag),
   .fault_dom  (fault_dom),
   .dis_err    (dis_err),
   .retry_lock (retry_lock)
);

// File: tb/tb_sd_shutdown_seq.sv
module tb_sd_shutdown_seq;

   localparam int N = 4;
   localparam int MIN_OFF = 40;
   localparam int ORD [N] = '{2, 0, 1, 3};
   localparam int DLY [N] = '{5, 2, 3, 1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   up_stage = 2'd0;
   logic         shut_req = 1'b0;
   logic         frame_tick = 1'b0;
   logic         cmd_ack = 1'b0;
   logic [N-1:0] rail_fault = '0;
   logic [N-1:0] hold_mask = '0;
   logic [N-1:0] rail_low;
   logic         cmd_req, cmd_sel, if_park, restart_ok;
   logic         fault_flag, dis_err, retry_lock;
   logic [N-1:0] rail_off;
   logic [1:0]   fault_dom;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int rise_t [N];
   logic [N-1:0] prev_off = '1;
   bit saw_cmd = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // comparators follow the force-off outputs unless held high
   assign rail_low = rail_off & ~hold_mask;

   sd_shutdown_seq #(
      .N_RAIL      (N),
      .RAIL_ORDER  (32'h0000_3102),
      .STEP_DLY    (128'h0001_0003_0002_0005),
      .DEP_MASK    (64'h0000_0000_0F03_0002),
      .FRAMES_DOFF (2),
      .FRAMES_SLP  (3),
      .MIN_OFF     (MIN_OFF),
      .DIS_TMO     (200),
      .MAX_RETRY   (2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .up_stage(up_stage), .shut_req(shut_req),
      .frame_tick(frame_tick), .cmd_ack(cmd_ack), .rail_fault(rail_fault),
      .rail_low(rail_low), .cmd_req(cmd_req), .cmd_sel(cmd_sel),
      .if_park(if_park), .rail_off(rail_off), .restart_ok(restart_ok),
      .fault_flag(fault_flag), .fault_dom(fault_dom), .dis_err(dis_err),
      .retry_lock(retry_lock)
   );

   always @(negedge clk) begin
      if (cmd_req) saw_cmd = 1;
      for (int i = 0; i < N; i++) begin
         if (rail_off[i] && !prev_off[i]) rise_t[i] = cyc;
      end
      prev_off = rail_off;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      cycles(3);
      chk(rail_off == 4'hF, "R1 rail_off", int'(rail_off), 15);
      chk(if_park == 1'b1, "R1 if_park", int'(if_park), 1);
      chk(cmd_req == 1'b0, "R1 cmd_req", int'(cmd_req), 0);
      chk(restart_ok == 1'b0, "R1 restart_ok", int'(restart_ok), 0);
      chk({fault_flag, dis_err, retry_lock} == 3'b000, "R1 flags",
          int'({fault_flag, dis_err, retry_lock}), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_boot;
      cycles(20);
      chk(restart_ok == 1'b0, "R5 boot early", int'(restart_ok), 0);
      cycles(40);
      chk(restart_ok == 1'b1, "R5 boot permitted", int'(restart_ok), 1);
   endtask

   task automatic go_run(input logic [1:0] stg);
      up_stage = stg;
      cycles(2);
      chk(rail_off == 4'h0, "R10 rails on", int'(rail_off), 0);
      chk(if_park == 1'b0, "R10 interface live", int'(if_park), 0);
      saw_cmd = 0;
   endtask

   task automatic shut;
      shut_req = 1'b1;
      cycles(1);
      shut_req = 1'b0;
      up_stage = 2'd0;
   endtask

   task automatic ack;
      cmd_ack = 1'b1;
      cycles(1);
      cmd_ack = 1'b0;
   endtask

   task automatic frame;
      frame_tick = 1'b1;
      cycles(1);
      frame_tick = 1'b0;
      cycles(2);
   endtask

   task automatic wait_off;
      int n;
      n = 0;
      while (!restart_ok && n < 300) begin
         cycles(1);
         n++;
      end
      chk(restart_ok == 1'b1, "R5 restart reached", int'(restart_ok), 1);
   endtask

   task automatic chk_spacing(input string tag);
      for (int k = 0; k < N - 1; k++) begin
         chk(rise_t[ORD[k+1]] - rise_t[ORD[k]] == DLY[k] + 2, tag,
             rise_t[ORD[k+1]] - rise_t[ORD[k]], DLY[k] + 2);
      end
   endtask

   task automatic t_full;
      go_run(2'd3);
      shut;
      chk(cmd_req && !cmd_sel, "R2 display off first", int'({cmd_req, cmd_sel}), 2);
      cycles(5);
      chk(cmd_req && !cmd_sel, "R2 held until ack", int'({cmd_req, cmd_sel}), 2);
      chk(rail_off == 4'h0, "R2 no rail before ack", int'(rail_off), 0);
      ack;
      chk(cmd_req == 1'b0, "R2 released on ack", int'(cmd_req), 0);
      frame;
      chk(cmd_req == 1'b0, "R2 one frame too few", int'(cmd_req), 0);
      frame;
      chk(cmd_req && cmd_sel, "R2 sleep entry", int'({cmd_req, cmd_sel}), 3);
      ack;
      frame;
      frame;
      chk(rail_off == 4'h0 && !if_park, "R3 still waiting", int'({if_park, rail_off}), 0);
      frame;
      chk(if_park == 1'b1, "R3 parked", int'(if_park), 1);
      cycles(30);
      chk(rail_off == 4'hF, "R3 all off", int'(rail_off), 15);
      chk_spacing("R3 order and spacing");
      while (cyc < rise_t[3] + 20) cycles(1);
      chk(restart_ok == 1'b0, "R5 before min off", int'(restart_ok), 0);
      while (cyc < rise_t[3] + 60) cycles(1);
      chk(restart_ok == 1'b1, "R5 after min off", int'(restart_ok), 1);
   endtask

   task automatic t_stage2;
      go_run(2'd2);
      hold_mask = 4'b0001;
      shut;
      chk(cmd_req && cmd_sel, "R4 starts at sleep entry", int'({cmd_req, cmd_sel}), 3);
      ack;
      frame;
      frame;
      frame;
      cycles(100);
      chk(restart_ok == 1'b0, "R5 comparator high", int'(restart_ok), 0);
      hold_mask = '0;
      cycles(3);
      chk(restart_ok == 1'b1, "R5 comparator low", int'(restart_ok), 1);
   endtask

   task automatic t_stage1;
      go_run(2'd1);
      shut;
      chk(if_park == 1'b1 && cmd_req == 1'b0, "R4 no command", int'({if_park, cmd_req}), 2);
      cycles(30);
      chk(saw_cmd == 1'b0, "R4 command never asked", int'(saw_cmd), 0);
      chk(rail_off == 4'hF, "R4 rails off", int'(rail_off), 15);
      chk_spacing("R4 spacing");
      wait_off;
   endtask

   task automatic t_off_fault;
      rail_fault = 4'b0010;
      cycles(1);
      rail_fault = '0;
      cycles(1);
      chk(fault_flag == 1'b0, "R8 fault ignored", int'(fault_flag), 0);
      chk(rail_off == 4'hF, "R8 rails unchanged", int'(rail_off), 15);
      chk(restart_ok == 1'b1, "R8 restart unchanged", int'(restart_ok), 1);
   endtask

   task automatic t_fault(input logic [N-1:0] vec, input logic [N-1:0] exp_off,
                          input int exp_dom, input bit exp_lock);
      go_run(2'd3);
      rail_fault = vec;
      cycles(1);
      rail_fault = '0;
      chk(rail_off == exp_off, "R7 dependent rails off", int'(rail_off), int'(exp_off));
      chk(fault_flag == 1'b1, "R7 fault recorded", int'(fault_flag), 1);
      chk(int'(fault_dom) == exp_dom, "R7 fault domain", int'(fault_dom), exp_dom);
      cycles(30);
      chk(saw_cmd == 1'b0, "R7 no command", int'(saw_cmd), 0);
      chk(rail_off == 4'hF, "R7 all rails off", int'(rail_off), 15);
      if (!exp_lock) begin
         chk(retry_lock == 1'b0, "R9 below limit", int'(retry_lock), 0);
         wait_off;
      end else begin
         cycles(150);
         chk(retry_lock == 1'b1, "R9 locked", int'(retry_lock), 1);
         chk(restart_ok == 1'b0, "R9 restart refused", int'(restart_ok), 0);
         chk(rail_off == 4'hF, "R9 no restart", int'(rail_off), 15);
      end
   endtask

   task automatic t_timeout;
      go_run(2'd1);
      hold_mask = 4'b1000;
      shut;
      cycles(300);
      chk(dis_err == 1'b1, "R6 timeout flagged", int'(dis_err), 1);
      chk(restart_ok == 1'b0, "R6 restart blocked", int'(restart_ok), 0);
      hold_mask = '0;
      cycles(80);
      chk(dis_err == 1'b1, "R6 error sticky", int'(dis_err), 1);
      chk(restart_ok == 1'b0, "R6 still blocked", int'(restart_ok), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run;
   end

   initial begin
      t_reset;
      t_boot;
      t_full;
      t_stage2;
      t_off_fault;
      t_fault(4'b0100, 4'b0111, 2, 1'b0);
      t_stage1;
      t_fault(4'b0001, 4'b0011, 0, 1'b0);
      t_fault(4'b1010, 4'b1111, 1, 1'b1);
      up_stage = 2'd0;
      t_reset;
      t_boot;
      t_timeout;
      finish_run;
   end

endmodule